// File: doc/BRIEF.md
# Supply-Tracking Audio Peak Limiter

This block watches a stream of signed audio samples and decides, sample by sample, how many decibels of attenuation a downstream gain stage should apply. The decision rests on a limiting threshold that follows one of two monitored supply rails, so the limiter starts cutting gain earlier when the rail sags. The multiplier that applies the gain is not part of this block.

The threshold comes from one of two curves. In headroom mode it is the selected rail multiplied by a slope factor. Otherwise it is a piecewise-linear curve. It sits at a programmable ceiling while the rail is at or above a knee voltage. Below the knee it falls with the rail at a programmable slope, and it cannot drop below a programmable floor. When a sample's magnitude rises above the threshold, attenuation grows at an attack rate. It is then held for a programmable number of samples and recovers at a release rate.

All voltages, magnitudes, slopes and rates are unsigned fixed point with FRAC fractional bits (4.20 by default). Attenuation uses the same fraction width, with enough integer bits to reach 48 dB.

Top module: `supply_limiter`

## Requirements
- R1: `mode_i` selects the rail: 2'b01 tracks `vbat_i` and 2'b10 tracks `pvdd_i`. Both 2'b00 and 2'b11 disable the block. On any strobe taken while disabled, attenuation becomes 0, the hold count is cleared and `active_o` goes low.
- R2: With `headroom_en_i` high, the threshold is (supply × slope) >> FRAC, saturated to the all-ones DW-bit value.
- R3: In headroom mode a slope above 1.0 (1 << FRAC) places the threshold above the supply. A magnitude between the supply and that threshold causes no attenuation.
- R4: With `headroom_en_i` low and supply ≥ `knee_i`, the threshold equals `th_max_i`.
- R5: With `headroom_en_i` low and supply < `knee_i`, the threshold is `th_max_i` minus ((knee − supply) × slope) >> FRAC, or 0 if that reduction reaches `th_max_i`.
- R6: The falling threshold of R5 is raised to `th_min_i` when it would be lower.
- R7: A sample whose magnitude is strictly greater than the threshold adds `atk_rate_i` to the attenuation. The result is capped at 48 dB (48 << FRAC).
- R8: Each exceeding sample reloads the hold counter with `hold_len_i`. Each following non-exceeding sample decrements the counter while it is non-zero, and during that time attenuation does not change.
- R9: A non-exceeding sample that arrives with the hold counter at zero subtracts `rls_rate_i` from the attenuation, stopping at 0.
- R10: Outputs are registered. They change only on the clock edge at which `sample_valid_i` is high, and they reset to 0.
- R11: `active_o` is high exactly when `atten_o` is non-zero.
- R12: The sample magnitude is the two's-complement absolute value. The most negative code gives 2^(DW−1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sample_valid_i | input | 1 | Sample strobe |
| sample_i | input | DW | Signed audio sample |
| vbat_i | input | DW | Battery rail reading |
| pvdd_i | input | DW | Power-stage rail reading |
| mode_i | input | 2 | Rail select / disable |
| headroom_en_i | input | 1 | Proportional threshold mode |
| th_max_i | input | DW | Threshold ceiling |
| th_min_i | input | DW | Threshold floor |
| knee_i | input | DW | Supply knee voltage |
| slope_i | input | DW | Slope / proportion factor |
| atk_rate_i | input | DW | Attack step, dB per sample |
| rls_rate_i | input | DW | Release step, dB per sample |
| hold_len_i | input | HW | Hold length in samples |
| atten_o | output | AW | Attenuation in dB |
| active_o | output | 1 | Limiting active |

## Verification
The bench sweeps rail voltages and slopes across both threshold curves. At each point it probes magnitudes exactly at the computed threshold and one LSB above it. An off-by-one in the comparison, a missed knee, a missing floor or a missing saturation would move the attack to the wrong side of that edge. Attack sequences run past 48 dB to catch a cap that wraps around. Hold sequences retrigger partway through to catch a counter that fails to reload, and a release step larger than the remaining attenuation catches an underflow. Reserved mode, the most negative sample and idle cycles with large inputs but no strobe are each checked at the outputs.

// File: rtl/lim_pkg.sv
package lim_pkg;
  typedef enum logic [1:0] {
    SRC_OFF = 2'b00,
    SRC_BAT = 2'b01,
    SRC_PWR = 2'b10,
    SRC_RSV = 2'b11
  } src_sel_e;
endpackage

// File: rtl/lim_magnitude.sv
module lim_magnitude #(
  parameter int DW = 24
) (
  input  logic signed [DW-1:0] sample_i,
  output logic        [DW-1:0] mag_o
);
  always_comb begin
    if (sample_i[DW-1]) mag_o = ~sample_i + 1'b1;
    else                mag_o = sample_i;
  end
endmodule

// File: rtl/lim_threshold.sv
module lim_threshold #(
  parameter int DW   = 24,
  parameter int FRAC = 20
) (
  input  logic [DW-1:0] supply_i,
  input  logic          headroom_en_i,
  input  logic [DW-1:0] th_max_i,
  input  logic [DW-1:0] th_min_i,
  input  logic [DW-1:0] knee_i,
  input  logic [DW-1:0] slope_i,
  output logic [DW-1:0] th_o
);
  localparam int PW = 2 * DW;

  logic [PW-1:0] prod_hr, sh_hr, prod_dn, sh_dn;
  logic [DW-1:0] drop, base, th_hr, th_pw;

  always_comb begin
    prod_hr = {{DW{1'b0}}, supply_i} * {{DW{1'b0}}, slope_i};
    sh_hr   = prod_hr >> FRAC;
    th_hr   = (|sh_hr[PW-1:DW]) ? '1 : sh_hr[DW-1:0];

    drop    = (supply_i < knee_i) ? knee_i - supply_i : '0;
    prod_dn = {{DW{1'b0}}, drop} * {{DW{1'b0}}, slope_i};
    sh_dn   = prod_dn >> FRAC;
    base    = (sh_dn >= {{DW{1'b0}}, th_max_i}) ? '0 : th_max_i - sh_dn[DW-1:0];

    if (supply_i >= knee_i) th_pw = th_max_i;
    else                    th_pw = (base < th_min_i) ? th_min_i : base;

    th_o = headroom_en_i ? th_hr : th_pw;
  end
endmodule

// File: rtl/lim_gain_ctrl.sv
module lim_gain_ctrl #(
  parameter int DW      = 24,
  parameter int FRAC    = 20,
  parameter int HW      = 16,
  parameter int MAX_DB  = 48,
  localparam int AW     = FRAC + $clog2(MAX_DB + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          strobe_i,
  input  logic          enable_i,
  input  logic          over_i,
  input  logic [DW-1:0] atk_i,
  input  logic [DW-1:0] rls_i,
  input  logic [HW-1:0] hold_i,
  output logic [AW-1:0] atten_o,
  output logic          active_o
);
  localparam int SW = ((AW > DW) ? AW : DW) + 1;
  localparam logic [SW-1:0] MAX_ATT = SW'(MAX_DB) << FRAC;

  logic [AW-1:0] att_q, att_n;
  logic [HW-1:0] hold_q, hold_n;
  logic          act_q;
  logic [SW-1:0] sum_w, att_w, rls_w;

  always_comb begin
    att_w = SW'(att_q);
    rls_w = SW'(rls_i);
    sum_w = att_w + SW'(atk_i);
    att_n  = att_q;
    hold_n = hold_q;
    if (!enable_i) begin
      att_n  = '0;
      hold_n = '0;
    end else if (over_i) begin
      att_n  = (sum_w > MAX_ATT) ? AW'(MAX_ATT) : AW'(sum_w);
      hold_n = hold_i;
    end else if (hold_q != '0) begin
      hold_n = hold_q - 1'b1;
    end else begin
      att_n  = (att_w > rls_w) ? AW'(att_w - rls_w) : '0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      att_q  <= '0;
      hold_q <= '0;
      act_q  <= 1'b0;
    end else if (strobe_i) begin
      att_q  <= att_n;
      hold_q <= hold_n;
      act_q  <= (att_n != '0);
    end
  end

  assign atten_o  = att_q;
  assign active_o = act_q;
endmodule

// File: rtl/supply_limiter.sv
module supply_limiter
  import lim_pkg::*;
#(
  parameter int DW     = 24,
  parameter int FRAC   = 20,
  parameter int HW     = 16,
  parameter int MAX_DB = 48,
  localparam int AW    = FRAC + $clog2(MAX_DB + 1)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 sample_valid_i,
  input  logic signed [DW-1:0] sample_i,
  input  logic        [DW-1:0] vbat_i,
  input  logic        [DW-1:0] pvdd_i,
  input  logic        [1:0]    mode_i,
  input  logic                 headroom_en_i,
  input  logic        [DW-1:0] th_max_i,
  input  logic        [DW-1:0] th_min_i,
  input  logic        [DW-1:0] knee_i,
  input  logic        [DW-1:0] slope_i,
  input  logic        [DW-1:0] atk_rate_i,
  input  logic        [DW-1:0] rls_rate_i,
  input  logic        [HW-1:0] hold_len_i,
  output logic        [AW-1:0] atten_o,
  output logic                 active_o
);
  src_sel_e      src;
  logic          enable;
  logic [DW-1:0] supply, mag, th;

  assign src    = src_sel_e'(mode_i);
  assign enable = (src == SRC_BAT) || (src == SRC_PWR);
  assign supply = (src == SRC_BAT) ? vbat_i : pvdd_i;

  lim_magnitude #(.DW(DW)) u_mag (
    .sample_i (sample_i),
    .mag_o    (mag)
  );

  lim_threshold #(.DW(DW), .FRAC(FRAC)) u_th (
    .supply_i      (supply),
    .headroom_en_i (headroom_en_i),
    .th_max_i      (th_max_i),
    .th_min_i      (th_min_i),
    .knee_i        (knee_i),
    .slope_i       (slope_i),
    .th_o          (th)
  );

  lim_gain_ctrl #(.DW(DW), .FRAC(FRAC), .HW(HW), .MAX_DB(MAX_DB)) u_gain (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .strobe_i (sample_valid_i),
    .enable_i (enable),
    .over_i   (mag > th),
    .atk_i    (atk_rate_i),
    .rls_i    (rls_rate_i),
    .hold_i   (hold_len_i),
    .atten_o  (atten_o),
    .active_o (active_o)
  );
endmodule

// File: rtl/supply_limiter_chk.sv
module supply_limiter_chk #(
  parameter int DW     = 24,
  parameter int FRAC   = 20,
  parameter int MAX_DB = 48,
  localparam int AW    = FRAC + $clog2(MAX_DB + 1)
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          sample_valid_i,
  input logic [1:0]    mode_i,
  input logic [DW-1:0] atk_rate_i,
  input logic [DW-1:0] rls_rate_i,
  input logic [AW-1:0] atten_o,
  input logic          active_o
);
  localparam longint MAX_ATT = longint'(MAX_DB) << FRAC;

  assert_cap_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    longint'(atten_o) <= MAX_ATT);

  assert_disabled_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sample_valid_i && (mode_i == 2'b00 || mode_i == 2'b11)) |=> (atten_o == '0 && !active_o));

  assert_hold_no_strobe_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sample_valid_i |=> ($stable(atten_o) && $stable(active_o)));

  assert_attack_step_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_valid_i |=> longint'(atten_o) <= longint'($past(atten_o)) + longint'($past(atk_rate_i)));

  assert_release_step_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sample_valid_i && (mode_i == 2'b01 || mode_i == 2'b10)) |=>
      longint'(atten_o) + longint'($past(rls_rate_i)) >= longint'($past(atten_o)));

  assert_flag_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_o == (atten_o != '0));
endmodule

bind supply_limiter supply_limiter_chk #(.DW(DW), .FRAC(FRAC), .MAX_DB(MAX_DB)) u_chk (.*);

// File: tb/supply_limiter_tb.sv
module supply_limiter_tb;
  localparam int DW = 24, FRAC = 20, HW = 16, MAX_DB = 48;
  localparam int AW = FRAC + $clog2(MAX_DB + 1);
  localparam longint ONE = longint'(1) << FRAC;
  localparam longint CAP = longint'(MAX_DB) << FRAC;

  logic clk = 0, rst_n = 0, valid = 0, hr = 0;
  logic signed [DW-1:0] smp = '0;
  logic [DW-1:0] vbat = '0, pvdd = '0, thmax = '0, thmin = '0, knee = '0, slope = '0, atk = '0, rls = '0;
  logic [1:0] mode = 2'b00;
  logic [HW-1:0] hlen = '0;
  logic [AW-1:0] atten;
  logic active;

  int checks = 0, fails = 0;
  bit done = 0;
  longint m_att = 0, m_hold = 0;

  always #10 clk = ~clk;

  supply_limiter u_dut (
    .clk_i(clk), .rst_ni(rst_n), .sample_valid_i(valid), .sample_i(smp),
    .vbat_i(vbat), .pvdd_i(pvdd), .mode_i(mode), .headroom_en_i(hr),
    .th_max_i(thmax), .th_min_i(thmin), .knee_i(knee), .slope_i(slope),
    .atk_rate_i(atk), .rls_rate_i(rls), .hold_len_i(hlen),
    .atten_o(atten), .active_o(active));

  function automatic longint th_ref();
    longint sup, p, red, base;
    sup = (mode == 2'b01) ? longint'(vbat) : longint'(pvdd);
    if (hr) begin
      p = (sup * longint'(slope)) >> FRAC;
      return (p > 64'hFFFFFF) ? 64'hFFFFFF : p;
    end
    if (sup >= longint'(knee)) return longint'(thmax);
    red  = ((longint'(knee) - sup) * longint'(slope)) >> FRAC;
    base = (red >= longint'(thmax)) ? 0 : longint'(thmax) - red;
    return (base < longint'(thmin)) ? longint'(thmin) : base;
  endfunction

  task automatic model(input longint s);
    longint mag = (s < 0) ? -s : s;
    if (!(mode == 2'b01 || mode == 2'b10)) begin m_att = 0; m_hold = 0; end
    else if (mag > th_ref()) begin
      m_att = (m_att + longint'(atk) > CAP) ? CAP : m_att + longint'(atk);
      m_hold = longint'(hlen);
    end else if (m_hold > 0) m_hold--;
    else m_att = (m_att > longint'(rls)) ? m_att - longint'(rls) : 0;
  endtask

  task automatic check(input string tag);
    checks++;
    if (longint'(atten) != m_att || active != (m_att != 0)) begin
      fails++;
      $display("FAIL %s atten=%0d active=%0b expected atten=%0d active=%0b",
               tag, atten, active, m_att, m_att != 0);
    end
  endtask

  task automatic step(input longint s, input string tag);
    @(negedge clk);
    smp = s[DW-1:0];
    valid = 1;
    @(posedge clk);
    model(s);
    @(negedge clk);
    valid = 0;
    check(tag);
  endtask

  task automatic clear();
    logic [1:0] keep = mode;
    mode = 2'b00;
    step(0, "R1 clear");
    mode = keep;
  endtask

  task automatic probe(input string tag);
    longint th = th_ref();
    clear();
    if (th <= 64'h7FFFFF) step(th, tag);
    clear();
    if (th + 1 <= 64'h800000) step(-(th + 1), tag);
    clear();
    if (th + 1 <= 64'h7FFFFF) step(th + 1, tag);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    checks++;
    if (atten != '0 || active) begin
      fails++;
      $display("FAIL R10 reset atten=%0d active=%0b expected 0 0", atten, active);
    end

    // R1: rail select and disabled modes
    atk = 24'(ONE); rls = 24'(8 * ONE); hlen = 0; hr = 1; slope = 24'(ONE);
    vbat = 24'(3 * ONE); pvdd = 24'(5 * ONE);
    mode = 2'b01; step(4 * ONE, "R1 bat rail");
    mode = 2'b10; clear(); step(4 * ONE, "R1 pwr rail");
    step(6 * ONE, "R1 pwr rail over");
    mode = 2'b11; step(7 * ONE, "R1 reserved");
    mode = 2'b00; step(7 * ONE, "R1 off");

    // R2 R3: proportional threshold sweep
    mode = 2'b01; hr = 1;
    foreach (vbat[i]) begin end
    for (int si = 0; si < 5; si++) begin
      case (si)
        0: slope = 24'(ONE / 2);
        1: slope = 24'((ONE * 9) / 10);
        2: slope = 24'(ONE);
        3: slope = 24'((ONE * 11) / 10);
        default: slope = 24'((ONE * 3) / 2);
      endcase
      for (int vi = 0; vi < 5; vi++) begin
        vbat = 24'((ONE * (2 + 3 * vi)) / 2);
        probe(si >= 3 ? "R3 headroom above rail" : "R2 headroom");
      end
    end
    vbat = 24'hFFFFFF; slope = 24'(4 * ONE); probe("R2 saturate");

    // R4 R5 R6: piecewise curve sweep on the power rail
    mode = 2'b10; hr = 0; thmax = 24'(4 * ONE); knee = 24'(5 * ONE); thmin = 24'((3 * ONE) / 2);
    for (int si = 1; si <= 2; si++) begin
      slope = 24'(si * ONE);
      for (int vi = 0; vi <= 14; vi++) begin
        pvdd = 24'((vi * ONE) / 2);
        probe(vi >= 10 ? "R4 above knee" : "R5 R6 below knee");
      end
    end
    thmin = 0; slope = 24'(3 * ONE); pvdd = 24'(ONE); probe("R5 zero threshold");
    thmin = 24'(ONE); pvdd = 0; probe("R6 floor");

    // R12: most negative sample
    hr = 0; knee = 0; thmax = 24'h7FFFFF; clear();
    step(-(longint'(1) << (DW - 1)), "R12 most negative");

    // R7 R8 R9: attack, cap, hold retrigger, release underflow
    thmax = 24'(ONE); atk = 24'(6 * ONE); rls = 24'((5 * ONE) / 2); hlen = 3;
    clear();
    for (int k = 0; k < 10; k++) step(2 * ONE, "R7 attack cap");
    step(ONE, "R8 at threshold holds");
    step(0, "R8 hold");
    step(-2 * ONE, "R8 retrigger");
    for (int k = 0; k < 3; k++) step(ONE / 2, "R8 hold after reload");
    for (int k = 0; k < 22; k++) step(ONE / 4, "R9 release to zero");
    atk = 24'(ONE / 3); rls = 24'(ONE / 8); hlen = 0;
    for (int k = 0; k < 4; k++) step(3 * ONE, "R7 small attack");
    for (int k = 0; k < 12; k++) step(0, "R9 R11 release");

    // R10: no strobe, inputs moving
    step(3 * ONE, "R10 prime");
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      smp = 24'h7FFFFF; mode = (k % 2 == 0) ? 2'b00 : 2'b01;
      @(negedge clk);
      check("R10 no strobe");
    end
    mode = 2'b01;

    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule